// File: doc/BRIEF.md
# Serial Management Slave for a Gigabit PHY Model

This block is the management side of a modelled gigabit Ethernet PHY. It is clocked by the management clock and samples the serial data line on every rising edge. A frame is accepted only after a run of ones followed by the start pattern. The frame then carries an operation code, a PHY address and a register address, a turnaround and sixteen data bits. Reads and writes reach a small set of 16-bit registers: control, status, two identifier words, the local advertisement, the link partner ability and a PHY-specific status word.

The link state is taken straight from the `link_up` input. Status bit 2, the partner ability word and the specific status word follow that input with fixed resolved values. The control register can be written. Writing its top bit restores the defaults of every writable register. The slave drives the line only during the second turnaround bit and the read data bits. Otherwise `mdio_oe` is low and the board pull-up holds the line high.

Top module: `mdio_phy_slave`

## Requirements
- R1: After `rst_n` is asserted low, `mdio_oe` is 0 and the control register (address 0) reads 0x1140.
- R2: A frame is recognised only if at least `PRE_MIN` consecutive ones are sampled before the start pattern 0 then 1. A shorter preamble causes no line drive.
- R3: The opcode bits, sent first, read as 2'b10 for a read and 2'b01 for a write. The values 2'b00 and 2'b11 abort the frame, with no drive and no register change.
- R4: The 5-bit PHY address is sent after the opcode. A frame whose PHY address differs from `PHY_ADDR` is ignored, for reads and for writes.
- R5: On a read, `mdio_oe` is 0 during the first turnaround bit. During the second turnaround bit it is 1 with `mdio_out` at 0.
- R6: The 16 read data bits follow the turnaround MSB first, one bit per clock, with `mdio_oe` at 1. The line is released (`mdio_oe` = 0) in the next bit time.
- R7: Address 2 reads 0x0141 and address 3 reads the `EXT_ID` parameter.
- R8: A write to control (address 0) with bit 15 clear stores the written value. A write to advertisement (address 4) stores the written value. The default of address 4 is 0x01E1.
- R9: A write to control with bit 15 set restores control to 0x1140 and advertisement to 0x01E1. Bit 15 then reads as 0.
- R10: Status (address 1) reads 0x7949 with bit 2 equal to `link_up`.
- R11: Specific status (address 17) reads 0xBC08 while `link_up` is 1 and 0x0000 otherwise. Partner ability (address 5) reads 0x41E1 while `link_up` is 1 and 0x0000 otherwise.
- R12: Writes to the read-only addresses 1, 2, 3, 5 and 17 leave their read values unchanged.
- R13: Unimplemented addresses read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock, rising edge samples the line |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| link_up | input | 1 | Link state applied to the status words |
| mdio_in | input | 1 | Sampled value of the management data line |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The bench builds the slave with `PHY_ADDR` = 3 and `EXT_ID` = 0x0C24, both different from the defaults. A strap match can therefore only pass if it honours the parameter, and the identifier check proves that the model value reaches address 3. The neighbouring address 4 is used for the wrong-address frames. `PRE_MIN` keeps its value of 32, so both a full preamble and a 20-bit preamble can be exercised at low cost.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_OPADR,
    ST_TA_RD,
    ST_TA_WR,
    ST_RD,
    ST_WR
  } mgmt_state_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADR_W  = 5;
  localparam int unsigned HDR_W  = 2 + 2 * ADR_W;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [ADR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADR_W-1:0] A_STAT = 5'd1;
  localparam logic [ADR_W-1:0] A_ID1  = 5'd2;
  localparam logic [ADR_W-1:0] A_ID2  = 5'd3;
  localparam logic [ADR_W-1:0] A_ADV  = 5'd4;
  localparam logic [ADR_W-1:0] A_LPA  = 5'd5;
  localparam logic [ADR_W-1:0] A_SPEC = 5'd17;

  localparam logic [WORD_W-1:0] CTRL_DEF  = 16'h1140;
  localparam logic [WORD_W-1:0] ADV_DEF   = 16'h01E1;
  localparam logic [WORD_W-1:0] STAT_BASE = 16'h7949;
  localparam logic [WORD_W-1:0] SPEC_UP   = 16'hBC08;
  localparam logic [WORD_W-1:0] LPA_UP    = 16'h41E1;
  localparam logic [WORD_W-1:0] ID1_VAL   = 16'h0141;

  // status word: fixed capability bits plus the link flag in bit 2
  function automatic logic [WORD_W-1:0] status_word(input logic link);
    return STAT_BASE | {13'd0, link, 2'b00};
  endfunction

  // resolved specific status, only meaningful with the link up
  function automatic logic [WORD_W-1:0] spec_word(input logic link);
    return link ? SPEC_UP : '0;
  endfunction

  // header layout, first bit in the MSB: {op[1:0], phy[4:0], reg[4:0]}
  function automatic logic hdr_accept(input logic [HDR_W-1:0] hdr,
                                      input logic [ADR_W-1:0] strap);
    return ((hdr[HDR_W-1 -: 2] == OP_RD) || (hdr[HDR_W-1 -: 2] == OP_WR))
           && (hdr[2*ADR_W-1 -: ADR_W] == strap);
  endfunction

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_phy_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1,
  parameter int unsigned PRE_MIN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADR_W-1:0]  rd_addr,
  output logic              wr_strobe,
  output logic [ADR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              sync_hit,
  output logic              mdio_out,
  output logic              mdio_oe
);

  localparam int unsigned PRE_W = $clog2(PRE_MIN + 1);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_MIN);

  mgmt_state_e        state;
  logic [PRE_W-1:0]   pre_cnt;
  logic [CNT_W-1:0]   cnt;
  logic [WORD_W-1:0]  acc;
  logic [ADR_W-1:0]   reg_adr;
  logic [HDR_W-1:0]   hdr_next;
  logic [WORD_W-1:0]  shift_in;

  assign shift_in = {acc[WORD_W-2:0], mdio_in};
  assign hdr_next = shift_in[HDR_W-1:0];

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pre_cnt <= '0;
      cnt     <= '0;
      acc     <= '0;
      reg_adr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (mdio_in) begin
            if (pre_cnt != PRE_TOP) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PRE_TOP) state <= ST_START;
            pre_cnt <= '0;
          end
        end
        ST_START: begin
          if (mdio_in) begin
            state <= ST_OPADR;
            cnt   <= CNT_W'(HDR_W - 1);
            acc   <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_OPADR: begin
          acc <= shift_in;
          if (cnt == '0) begin
            reg_adr <= hdr_next[ADR_W-1:0];
            cnt     <= CNT_W'(1);
            if (!hdr_accept(hdr_next, PHY_ADDR)) state <= ST_IDLE;
            else if (hdr_next[HDR_W-1 -: 2] == OP_RD) state <= ST_TA_RD;
            else state <= ST_TA_WR;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TA_RD: begin
          if (cnt == '0) begin
            state <= ST_RD;
            acc   <= rd_data;
            cnt   <= CNT_W'(WORD_W - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TA_WR: begin
          if (cnt == '0) begin
            state <= ST_WR;
            cnt   <= CNT_W'(WORD_W - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RD: begin
          acc <= {acc[WORD_W-2:0], 1'b0};
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_WR: begin
          acc <= shift_in;
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr   = reg_adr;
  assign wr_addr   = reg_adr;
  assign wr_data   = shift_in;
  assign wr_strobe = (state == ST_WR) && (cnt == '0);
  assign sync_hit  = (state == ST_START);
  assign mdio_oe   = ((state == ST_TA_RD) && (cnt == '0)) || (state == ST_RD);
  assign mdio_out  = (state == ST_RD) ? acc[WORD_W-1] : 1'b0;

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_phy_pkg::*;
#(
  parameter logic [15:0] EXT_ID = 16'h0C50
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              wr_strobe,
  input  logic [ADR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] ctrl_q
);

  logic [WORD_W-1:0] adv_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
    end else if (wr_strobe) begin
      if (wr_addr == A_CTRL) begin
        if (wr_data[15]) begin
          ctrl_q <= CTRL_DEF;
          adv_q  <= ADV_DEF;
        end else begin
          ctrl_q <= wr_data;
        end
      end else if (wr_addr == A_ADV) begin
        adv_q <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_STAT:  rd_data = status_word(link_up);
      A_ID1:   rd_data = ID1_VAL;
      A_ID2:   rd_data = EXT_ID;
      A_ADV:   rd_data = adv_q;
      A_LPA:   rd_data = link_up ? LPA_UP : '0;
      A_SPEC:  rd_data = spec_word(link_up);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave
  import mdio_phy_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR = 5'd1,
  parameter logic [15:0] EXT_ID   = 16'h0C50,
  parameter int unsigned PRE_MIN  = 32
) (
  input  logic mdc,
  input  logic rst_n,
  input  logic link_up,
  input  logic mdio_in,
  output logic mdio_out,
  output logic mdio_oe
);

  logic [ADR_W-1:0]  rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic              wr_strobe;
  logic [ADR_W-1:0]  wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              sync_hit;
  logic [WORD_W-1:0] ctrl_q;

  mdio_frame_fsm #(.PHY_ADDR(PHY_ADDR), .PRE_MIN(PRE_MIN)) u_fsm (
    .mdc       (mdc),
    .rst_n     (rst_n),
    .mdio_in   (mdio_in),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sync_hit  (sync_hit),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe)
  );

  mdio_phy_regs #(.EXT_ID(EXT_ID)) u_regs (
    .mdc       (mdc),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ctrl_q    (ctrl_q)
  );

endmodule

// File: rtl/mdio_phy_checker.sv
module mdio_phy_checker
  import mdio_phy_pkg::*;
#(
  parameter int unsigned PRE_MIN = 32
) (
  input logic              mdc,
  input logic              rst_n,
  input logic              mdio_in,
  input logic              mdio_oe,
  input logic              mdio_out,
  input logic              sync_hit,
  input logic              wr_strobe,
  input logic [ADR_W-1:0]  wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] ctrl_q
);

  logic [7:0] ones_run;
  logic [5:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ones_run <= '0;
      oe_run   <= '0;
    end else begin
      if (!mdio_in) ones_run <= '0;
      else if (ones_run != 8'hFF) ones_run <= ones_run + 1'b1;
      if (!mdio_oe) oe_run <= '0;
      else if (oe_run != 6'h3F) oe_run <= oe_run + 1'b1;
    end
  end

  // R2: start accepted only after a long enough run of ones
  a_r2_preamble_seen: assert property (@(posedge mdc) disable iff (!rst_n)
    sync_hit |-> ($past(ones_run) >= 8'(PRE_MIN)));

  // R5: the first driven bit is the zero of the turnaround
  a_r5_first_drive_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> (mdio_out == 1'b0));

  // R6: drive window never exceeds turnaround bit plus 16 data bits
  a_r6_drive_window_max: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run <= 6'd17);

  // R8: plain control write is stored
  a_r8_ctrl_write: assert property (@(posedge mdc) disable iff (!rst_n)
    (wr_strobe && (wr_addr == A_CTRL) && !wr_data[15]) |=> (ctrl_q == $past(wr_data)));

  // R9: control write with the top bit restores the default
  a_r9_ctrl_reset_clears: assert property (@(posedge mdc) disable iff (!rst_n)
    (wr_strobe && (wr_addr == A_CTRL) && wr_data[15]) |=> (ctrl_q == CTRL_DEF));

endmodule

bind mdio_phy_slave mdio_phy_checker #(.PRE_MIN(PRE_MIN)) u_chk (
  .mdc       (mdc),
  .rst_n     (rst_n),
  .mdio_in   (mdio_in),
  .mdio_oe   (mdio_oe),
  .mdio_out  (mdio_out),
  .sync_hit  (sync_hit),
  .wr_strobe (wr_strobe),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ctrl_q    (ctrl_q)
);

// File: tb/mdio_phy_slave_test.sv
module mdio_phy_slave_test;

  localparam logic [4:0]  PHY  = 5'd3;
  localparam logic [15:0] EXID = 16'h0C24;
  localparam int NV = 17;

  // {req[3:0], is_write, addr[4:0], value[15:0]}; link_up held at 0
  localparam logic [25:0] VEC [NV] = '{
    {4'd1,  1'b0, 5'd0,  16'h1140},  // R1 control default
    {4'd7,  1'b0, 5'd2,  16'h0141},  // R7
    {4'd7,  1'b0, 5'd3,  16'h0C24},  // R7 model id from parameter
    {4'd10, 1'b0, 5'd1,  16'h7949},  // R10 link down
    {4'd11, 1'b0, 5'd17, 16'h0000},  // R11 link down
    {4'd8,  1'b1, 5'd0,  16'h0100},
    {4'd8,  1'b0, 5'd0,  16'h0100},  // R8
    {4'd8,  1'b1, 5'd4,  16'h0061},
    {4'd8,  1'b0, 5'd4,  16'h0061},  // R8
    {4'd12, 1'b1, 5'd2,  16'hFFFF},
    {4'd12, 1'b0, 5'd2,  16'h0141},  // R12
    {4'd9,  1'b1, 5'd0,  16'h8000},
    {4'd9,  1'b0, 5'd0,  16'h1140},  // R9
    {4'd9,  1'b0, 5'd4,  16'h01E1},  // R9
    {4'd13, 1'b0, 5'd9,  16'h0000},  // R13
    {4'd12, 1'b1, 5'd17, 16'h1234},
    {4'd12, 1'b0, 5'd17, 16'h0000}   // R12
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0;
  logic mdio_in = 1'b1;
  logic mdio_out;
  logic mdio_oe;
  int   n_tests = 0;
  int   n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mdio_phy_slave #(.PHY_ADDR(PHY), .EXT_ID(EXID)) uut (
    .mdc      (clk),
    .rst_n    (rst_n),
    .link_up  (link_up),
    .mdio_in  (mdio_in),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    mdio_in = b;
    @(posedge clk);
  endtask

  task automatic send_header(input int pre, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra);
    repeat (pre) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  task automatic do_read(input logic [4:0] ra, output logic [15:0] data);
    logic all_on;
    all_on = 1'b1;
    send_header(32, 2'b10, PHY, ra);
    @(negedge clk);
    mdio_in = 1'b1;
    chk("R5 ta1 oe", {15'd0, mdio_oe}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 ta2 oe/out", {14'd0, mdio_oe, mdio_out}, 16'd2);
    for (int i = 15; i >= 0; i--) begin
      @(posedge clk);
      @(negedge clk);
      data[i] = mdio_out;
      all_on  = all_on & mdio_oe;
    end
    chk("R6 drive during data", {15'd0, all_on}, 16'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R6 release", {15'd0, mdio_oe}, 16'd0);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    send_header(32, 2'b01, phy, ra);
    send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    send_bit(1'b1);
  endtask

  task automatic expect_silent(input string req);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      seen = seen | mdio_oe;
    end
    chk(req, {15'd0, seen}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 oe in reset", {15'd0, mdio_oe}, 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        do_write(PHY, VEC[i][20:16], VEC[i][15:0]);
      end else begin
        do_read(VEC[i][20:16], rd);
        chk($sformatf("R%0d table entry %0d", VEC[i][25:22], i), rd, VEC[i][15:0]);
      end
    end

    // R10 R11: link toggling
    link_up = 1'b1;
    do_read(5'd1, rd);  chk("R10 link up", rd, 16'h794D);
    do_read(5'd17, rd); chk("R11 spec link up", rd, 16'hBC08);
    do_read(5'd5, rd);  chk("R11 partner link up", rd, 16'h41E1);
    do_write(PHY, 5'd1, 16'h0000);
    do_read(5'd1, rd);  chk("R12 status write ignored", rd, 16'h794D);
    link_up = 1'b0;
    do_read(5'd1, rd);  chk("R10 link down again", rd, 16'h7949);
    do_read(5'd5, rd);  chk("R11 partner link down", rd, 16'h0000);

    // R2: short preamble
    send_header(20, 2'b10, PHY, 5'd2);
    expect_silent("R2 short preamble");

    // R3: invalid opcodes
    send_header(32, 2'b11, PHY, 5'd2);
    expect_silent("R3 opcode 11");
    send_header(32, 2'b00, PHY, 5'd2);
    expect_silent("R3 opcode 00");

    // R4: foreign PHY address, read and write
    send_header(32, 2'b10, PHY + 5'd1, 5'd2);
    expect_silent("R4 foreign read");
    do_write(PHY + 5'd1, 5'd0, 16'h0000);
    do_read(5'd0, rd);  chk("R4 foreign write ignored", rd, 16'h1140);

    // R6: MSB first with an asymmetric pattern
    do_write(PHY, 5'd4, 16'h8001 ^ 16'h0003);
    do_read(5'd4, rd);  chk("R6 bit order", rd, 16'h8002);

    // R1: hardware reset restores control and advertisement
    do_write(PHY, 5'd0, 16'h2100);
    do_read(5'd0, rd);  chk("R8 ctrl 2100", rd, 16'h2100);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(5'd0, rd);  chk("R1 ctrl after hard reset", rd, 16'h1140);
    do_read(5'd4, rd);  chk("R1 adv after hard reset", rd, 16'h01E1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule